// File: doc/BRIEF.md
# Wrapping Four-Beat Burst Address Sequencer

This block produces the address stream for a burst access to a memory array. A load strobe latches a start address. Each later advance request steps only the low address bits to the next beat of the burst. The bits above them keep the value captured at the load. With the default two-bit beat field, a burst visits the four words of the naturally aligned group that holds the start address, and then wraps.

Two beat orders are supported. In linear order the low bits count upward from the start value, modulo the group size. In interleaved order the low bits are the start value XOR a beat count that runs 0, 1, 2, 3. The order select is sampled together with the start address, so the order stays fixed for the whole burst. The advance input is active low. A load always takes precedence over an advance in the same cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no load, `addr_o` is all zeros.
- R2: A clock edge with `load_i` high makes `addr_o` equal to `start_addr_i` from that edge, whatever `adv_n_i` is at that edge.
- R3: A clock edge with `load_i` low and `adv_n_i` high leaves `addr_o` unchanged.
- R4: Between loads, the bits of `addr_o` above the low `BEAT_W` bits do not change, including when the low bits wrap (no carry out of the low field).
- R5: When the burst was loaded with `mode_i` = 0 (linear), each advance (`adv_n_i` low, `load_i` low) makes the low `BEAT_W` bits of `addr_o` equal to their previous value plus one, modulo 2^BEAT_W.
- R6: When the burst was loaded with `mode_i` = 1 (interleaved), after k advances the low `BEAT_W` bits equal the loaded start low bits XOR (k mod 2^BEAT_W).
- R7: `mode_i` is used only at a load edge. Changing it during a burst does not change the order of that burst.
- R8: Advances continue past the last beat without stopping. After 2^BEAT_W advances, `addr_o` again equals the loaded start address.
- R9: A load in the middle of a burst resets the beat count to zero, so the sequence restarts from the new start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All state updates on its rising edge. |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block. |
| load_i | input | 1 | Start-of-burst strobe, active high. |
| start_addr_i | input | ADDR_W | Start address, captured when `load_i` is high. |
| adv_n_i | input | 1 | Advance request, active low. |
| mode_i | input | 1 | Beat order, sampled at load: 0 linear, 1 interleaved. |
| addr_o | output | ADDR_W | Current burst address. |

## Verification
The bench builds the block with `ADDR_W` = 8 and `BEAT_W` = 2. This gives 64 distinct upper-address values and four beats per burst. Random start addresses therefore often land on all-ones upper bits, where a carry out of the low field would show at once, and on every low start offset in both orders. Random load, advance and mode traffic runs long enough to produce many full wraps and many loads in the middle of a burst. Directed sequences pin the exact beat values for a linear burst started at offset 2 and for an interleaved burst started at offset 1.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Beat ordering selected at burst start.
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

endpackage

// File: rtl/bag_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module bag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bag_base_reg.sv
// Holds the burst context captured at a load: upper bits, start low bits, order.
module bag_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2,
  localparam int UP_W  = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output logic [UP_W-1:0]   upper_o,
  output logic [BEAT_W-1:0] start_lo_o,
  output order_e            order_o
);

  logic [UP_W-1:0]   upper_q,  upper_d;
  logic [BEAT_W-1:0] lo_q,     lo_d;
  order_e            order_q,  order_d;

  always_comb begin
    upper_d = upper_q;
    lo_d    = lo_q;
    order_d = order_q;
    if (load_i) begin
      upper_d = addr_i[ADDR_W-1:BEAT_W];
      lo_d    = addr_i[BEAT_W-1:0];
      order_d = order_e'(mode_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      lo_q    <= '0;
      order_q <= ORD_LINEAR;
    end else if (load_i) begin
      upper_q <= upper_d;
      lo_q    <= lo_d;
      order_q <= order_d;
    end
  end

  assign upper_o    = upper_q;
  assign start_lo_o = lo_q;
  assign order_o    = order_q;

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(upper_q)); // R4
  AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(order_q)); // R7

endmodule

// File: rtl/bag_beat_ctr.sv
// Beat counter: cleared by a load, stepped by an advance, wraps freely.
module bag_beat_ctr #(
  parameter int BEAT_W = 2,
  localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);

  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              beat_en;

  assign beat_en = clear_i | step_i;

  always_comb begin
    if (clear_i) beat_d = '0;
    else         beat_d = beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat_o = beat_q;

  AST_BEAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (beat_q == '0)); // R9
  AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && step_i && beat_q == LAST) |=> (beat_q == '0)); // R8
  AST_BEAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !step_i) |=> $stable(beat_q)); // R3

endmodule

// File: rtl/bag_order_map.sv
// Combines the start low bits with the beat count according to the order.
module bag_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] lo_o
);

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] xor_lo;

  assign lin_lo = start_lo_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
    assign xor_lo[b] = start_lo_i[b] ^ beat_i[b];
  end

  always_comb begin
    case (order_i)
      ORD_XOR: lo_o = xor_lo;
      default: lo_o = lin_lo;
    endcase
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_n_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int UP_W = ADDR_W - BEAT_W;

  logic              rst_q_n;
  logic              step;
  logic [UP_W-1:0]   upper;
  logic [BEAT_W-1:0] start_lo;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lo;
  order_e            order;

  assign step = !load_i && !adv_n_i;

  bag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  bag_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .load_i     (load_i),
    .addr_i     (start_addr_i),
    .mode_i     (mode_i),
    .upper_o    (upper),
    .start_lo_o (start_lo),
    .order_o    (order)
  );

  bag_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clear_i (load_i),
    .step_i  (step),
    .beat_o  (beat)
  );

  bag_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_lo_i (start_lo),
    .beat_i     (beat),
    .order_i    (order),
    .lo_o       (lo)
  );

  assign addr_o = {upper, lo};

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_q_n)
    load_i |=> (addr_o == $past(start_addr_i))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!load_i && adv_n_i) |=> $stable(addr_o)); // R3
  AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_q_n)
    step |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]))); // R4
  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step && order == ORD_LINEAR)
      |=> (addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + 1'b1)); // R5
  AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step && order == ORD_XOR)
      |=> ((addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) == (beat ^ $past(beat)))); // R6

endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

  localparam int AW = 8;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_i;
  logic [AW-1:0] start_addr_i;
  logic          adv_n_i;
  logic          mode_i;
  logic [AW-1:0] addr_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  // model state
  logic [AW-BW-1:0] m_up;
  logic [BW-1:0]    m_lo0;
  logic [BW-1:0]    m_beat;
  logic             m_ord;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
    .adv_n_i(adv_n_i), .mode_i(mode_i), .addr_o(addr_o)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [BW-1:0] lo;
    lo = m_ord ? (m_lo0 ^ m_beat) : (m_lo0 + m_beat);
    return {m_up, lo};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one cycle: drive at negedge, update model, sample 1 ns after posedge
  task automatic cyc(input logic ld, input logic [AW-1:0] a, input logic advn, input logic md);
    string req;
    @(negedge clk);
    load_i = ld; start_addr_i = a; adv_n_i = advn; mode_i = md;
    @(posedge clk);
    if (ld) begin
      m_up = a[AW-1:BW]; m_lo0 = a[BW-1:0]; m_beat = '0; m_ord = md;
      req = "R2";
    end else if (!advn) begin
      m_beat = m_beat + 1'b1;
      req = m_ord ? "R6" : "R5";
    end else begin
      req = "R3";
    end
    #1;
    check(req, addr_o, exp_addr());
    check("R4", {addr_o[AW-1:BW], 2'b00}, {m_up, 2'b00});
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; load_i = 1'b0; start_addr_i = '0; adv_n_i = 1'b1; mode_i = 1'b0;
    m_up = '0; m_lo0 = '0; m_beat = '0; m_ord = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1", addr_o, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1", addr_o, '0);

    // R5 + R4: linear from offset 2 with all-ones upper bits, no carry
    cyc(1, 8'hFE, 1, 0);
    check("R2", addr_o, 8'hFE);
    cyc(0, '0, 0, 0); check("R5", addr_o, 8'hFF);
    cyc(0, '0, 0, 0); check("R4", addr_o, 8'hFC);
    cyc(0, '0, 0, 0); check("R5", addr_o, 8'hFD);
    cyc(0, '0, 0, 0); check("R8", addr_o, 8'hFE);
    cyc(0, '0, 0, 0); check("R8", addr_o, 8'hFF);
    cyc(0, '0, 1, 1); check("R3", addr_o, 8'hFF);

    // R6 + R7: interleaved from offset 1, mode toggled during the burst
    cyc(1, 8'h25, 1, 1);
    cyc(0, '0, 0, 0); check("R7", addr_o, 8'h24);
    cyc(0, '0, 0, 1); check("R6", addr_o, 8'h27);
    cyc(0, '0, 0, 0); check("R7", addr_o, 8'h26);
    cyc(0, '0, 0, 1); check("R8", addr_o, 8'h25);

    // R9 + R2: load together with advance, mid-burst
    cyc(0, '0, 0, 0);
    cyc(1, 8'h42, 0, 1); check("R9", addr_o, 8'h42);
    cyc(0, '0, 0, 1); check("R9", addr_o, 8'h43);
    cyc(0, '0, 0, 1); check("R6", addr_o, 8'h40);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic ld;
      ld = (($urandom % 8) == 0);
      cyc(ld, AW'($urandom), logic'($urandom % 3 == 0), logic'($urandom));
    end

    finish_run();
  end

endmodule